// File: doc/BRIEF.md
# I2C Master Receive Buffer with Clock Stretch

This block sits between the bit-level shift engine of an I2C master and software. Each completed byte from the engine lands either in a 16-entry FIFO or in a single data register, depending on a mode bit. While software has not taken the data, the block pulls SCL low to stretch the bus clock, which stalls the engine and the remote transmitter. In FIFO mode the stretch starts once the FIFO holds a programmable number of bytes. In single-register mode it starts when a byte arrives and ends when software clears a ready flag.

The block also watches both bus lines through synchronizers. It reports the live SCL level and a bus-busy status that is set by START and cleared by STOP. A test override lets two register bits pull SCL and SDA directly. Both lines are open-drain: the outputs only ask for a line to be pulled low or released.

Software sees four byte-wide registers. CTRL at address 0 holds bit 7 single-register mode (0 = FIFO), bit 6 force-SCL (read: synchronized SCL level), bit 5 force-SDA (read: bus busy), bit 4 override and bit 3 enable; bits 2:0 read 0. TRIG at address 1 holds the trigger level in bits 3:0. STAT at address 2 holds bit 0 FIFO-full flag, bit 1 ready flag and bits 7:3 FIFO count. DATA at address 3 is read-only receive data.

Top module: `i2c_rx_buffer`

## Requirements
- R1: After reset, TRIG reads 0x00, STAT reads 0x00, CTRL bits 7, 4 and 3 read 0, and scl_pull and sda_pull are 0.
- R2: With CTRL bit 3 = 1 and CTRL bit 7 = 0, each rx_valid pulse stores rx_byte in the FIFO. STAT bits 7:3 give the byte count. Each read of DATA returns the oldest byte and removes it.
- R3: The STAT bit 0 full flag is 1 while the FIFO count is at least TRIG+1. In FIFO mode, with enable = 1 and override = 0, scl_pull is 1 while that flag is 1.
- R4: A DATA read that takes the count below TRIG+1 clears the full flag and releases scl_pull from the next cycle.
- R5: The FIFO holds at most 16 bytes. A byte arriving while it is full is dropped. A DATA read of an empty FIFO returns 0x00 and leaves the count at 0.
- R6: In single-register mode (CTRL bit 7 = 1, enable = 1), a received byte is stored, sets STAT bit 1, and can be read at DATA any number of times without being consumed. scl_pull stays 1 until software writes STAT with bit 1 = 0. Writing STAT with bit 1 = 1 has no effect.
- R7: With enable = 0, received bytes are ignored in both modes, and scl_pull is 0 unless override is set.
- R8: With override = 1, scl_pull equals the inverse of CTRL bit 6 as written and sda_pull equals the inverse of CTRL bit 5 as written. With override = 0, sda_pull is 0.
- R9: A read of CTRL bit 6 returns the SCL pin level after the synchronizer, also while reset is held.
- R10: CTRL bit 5 reads 1 after a START (SDA falling while SCL is high) and 0 after a STOP (SDA rising while SCL is high). An SDA edge while SCL is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on rx_byte |
| rx_byte | input | 8 | Received byte from the shift engine |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a DATA read consumes a FIFO byte) |
| reg_addr | input | 2 | Register address: 0 CTRL, 1 TRIG, 2 STAT, 3 DATA |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_pull | output | 1 | 1 = pull SCL low, 0 = release |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release |

## Verification
A wrong FIFO count or pointer shows up on the next STAT or DATA read as a wrong count field or a byte out of order. It also moves the stretch edge by one byte, so scl_pull is high or low one push too early or too late in the cycle right after the push or read. A ready flag that is stuck or not held appears on scl_pull the cycle after the byte arrives or the clearing write. A fault in the synchronizer or in START/STOP detection shows in CTRL bits 6 and 5 within three or four cycles of the pin change.

// File: rtl/i2c_rxb_pkg.sv
// Package: register addresses, CTRL/STAT bit positions and the control
// register layout shared by the receive buffer and its checker.
package i2c_rxb_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_TRIG = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_DATA = 2'd3
    } reg_addr_e;

    // CTRL bit positions
    localparam int CTRL_SINGLE = 7;
    localparam int CTRL_FSCL   = 6;
    localparam int CTRL_FSDA   = 5;
    localparam int CTRL_OVR    = 4;
    localparam int CTRL_EN     = 3;

    // STAT bit positions
    localparam int STAT_FULL    = 0;
    localparam int STAT_RDY     = 1;
    localparam int STAT_CNT_LSB = 3;
    localparam int STAT_CNT_W   = 5;

    typedef struct packed {
        logic buf_single;
        logic force_scl;
        logic force_sda;
        logic override;
        logic enable;
    } ctrl_t;

endpackage

// File: rtl/i2c_rxb_sync.sv
// Multi-stage synchronizer, one chain per bit.
// Assumes STAGES >= 2. The flops carry no reset, so the synchronized pin
// levels keep tracking the bus while the block is held in reset.
module i2c_rxb_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw pin level through the chain
        always_ff @(posedge clk) begin
            chain <= {chain[STAGES-2:0], d[b]};
        end

        assign q[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/i2c_rxb_busmon.sv
// Bus monitor: detects START and STOP on synchronized SCL/SDA and keeps a
// busy flag. Assumes both inputs are already synchronized to clk.
module i2c_rxb_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic busy
);

    logic sda_prev;
    logic start_det;
    logic stop_det;

    // Previous SDA sample for edge detection; tracks even in reset
    always_ff @(posedge clk) begin
        sda_prev <= sda_s;
    end

    assign start_det = scl_s &  sda_prev & ~sda_s;
    assign stop_det  = scl_s & ~sda_prev &  sda_s;

    // Busy set by START, cleared by STOP
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (start_det) begin
            busy <= 1'b1;
        end else if (stop_det) begin
            busy <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_rxb_fifo.sv
// Receive FIFO with an occupancy count and a head view.
// A push while full is dropped; a pop while empty does nothing. Storage
// carries no reset; only pointers and count are reset.
module i2c_rxb_fifo #(
    parameter  int WIDTH = 8,
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic             push_ok;
    logic             pop_ok;

    assign push_ok = push && (int'(count) < DEPTH);
    assign pop_ok  = pop && (count != '0);

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + PW'(1);
    endfunction

    // Write a new byte into storage
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= din;
        end
    end

    // Advance pointers and the occupancy count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
            if (push_ok && !pop_ok)      count <= count + CW'(1);
            else if (pop_ok && !push_ok) count <= count - CW'(1);
        end
    end

    assign head = mem[rd_ptr];

endmodule

// File: rtl/i2c_rx_buffer.sv
// I2C master receive buffer with clock stretch.
// Stores received bytes in a FIFO or a single register and asks for SCL
// to be held low until software takes the data. Provides a test override
// for both lines, a synchronized SCL readback and a bus-busy flag.
// Assumes rx_valid is a one-cycle strobe and the outputs drive
// open-drain pads (1 = pull low).
module i2c_rx_buffer #(
    parameter int FIFO_DEPTH  = 16,
    parameter int TRIG_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_pull,
    output logic       sda_pull
);
    import i2c_rxb_pkg::*;

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    ctrl_t             ctrl_q;
    logic [TRIG_W-1:0] trig_q;
    logic [BYTE_W-1:0] single_q;
    logic              ready_q;

    logic [1:0]        pins_s;
    logic              scl_s;
    logic              sda_s;
    logic              bus_busy;

    logic              fifo_push;
    logic              fifo_pop;
    logic [BYTE_W-1:0] fifo_head;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              fifo_full;

    logic              take_single;
    logic              ready_clr;
    logic              stretch;

    // Bus line synchronizers
    i2c_rxb_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .d   ({scl_in, sda_in}),
        .q   (pins_s)
    );

    assign scl_s = pins_s[1];
    assign sda_s = pins_s[0];

    // START/STOP detection
    i2c_rxb_busmon u_busmon (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (scl_s),
        .sda_s (sda_s),
        .busy  (bus_busy)
    );

    // Receive path select
    assign fifo_push   = rx_valid && ctrl_q.enable && !ctrl_q.buf_single;
    assign take_single = rx_valid && ctrl_q.enable &&  ctrl_q.buf_single;
    assign fifo_pop    = reg_rd && (reg_addr == ADDR_DATA) && !ctrl_q.buf_single;
    assign ready_clr   = reg_wr && (reg_addr == ADDR_STAT) && !reg_wdata[STAT_RDY];

    i2c_rxb_fifo #(
        .WIDTH (BYTE_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .din   (rx_byte),
        .pop   (fifo_pop),
        .head  (fifo_head),
        .count (fifo_cnt)
    );

    // Full flag: count at or above trigger level plus one
    assign fifo_full = int'(fifo_cnt) > int'(trig_q);

    // Control and trigger registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            trig_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_CTRL) begin
                ctrl_q.buf_single <= reg_wdata[CTRL_SINGLE];
                ctrl_q.force_scl  <= reg_wdata[CTRL_FSCL];
                ctrl_q.force_sda  <= reg_wdata[CTRL_FSDA];
                ctrl_q.override   <= reg_wdata[CTRL_OVR];
                ctrl_q.enable     <= reg_wdata[CTRL_EN];
            end
            if (reg_addr == ADDR_TRIG) begin
                trig_q <= reg_wdata[TRIG_W-1:0];
            end
        end
    end

    // Single data register and its ready flag (arrival wins over clear)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            single_q <= '0;
            ready_q  <= 1'b0;
        end else if (take_single) begin
            single_q <= rx_byte;
            ready_q  <= 1'b1;
        end else if (ready_clr) begin
            ready_q  <= 1'b0;
        end
    end

    // Register read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CTRL_SINGLE] = ctrl_q.buf_single;
                reg_rdata[CTRL_FSCL]   = scl_s;
                reg_rdata[CTRL_FSDA]   = bus_busy;
                reg_rdata[CTRL_OVR]    = ctrl_q.override;
                reg_rdata[CTRL_EN]     = ctrl_q.enable;
            end
            ADDR_TRIG: reg_rdata[TRIG_W-1:0] = trig_q;
            ADDR_STAT: begin
                reg_rdata[STAT_FULL] = fifo_full;
                reg_rdata[STAT_RDY]  = ready_q;
                reg_rdata[STAT_CNT_LSB +: STAT_CNT_W] = STAT_CNT_W'(fifo_cnt);
            end
            default: begin
                if (ctrl_q.buf_single)    reg_rdata = single_q;
                else if (fifo_cnt != '0)  reg_rdata = fifo_head;
            end
        endcase
    end

    // Line control: override wins, else stretch on buffer state
    assign stretch  = ctrl_q.buf_single ? ready_q : fifo_full;
    assign scl_pull = ctrl_q.override ? !ctrl_q.force_scl : (ctrl_q.enable && stretch);
    assign sda_pull = ctrl_q.override && !ctrl_q.force_sda;

endmodule

// File: rtl/i2c_rx_buffer_chk.sv
// Checker for i2c_rx_buffer: relates the strobes, the buffer state and the
// line outputs over time. Attached to every instance by the bind below.
module i2c_rx_buffer_chk #(
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 5,
    parameter int TRIG_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [1:0]        reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              scl_pull,
    input logic              sda_pull,
    input logic              enable,
    input logic              override,
    input logic              buf_single,
    input logic [CNT_W-1:0]  fifo_cnt,
    input logic [TRIG_W-1:0] trig,
    input logic              ready
);

    assert_push_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && enable && !buf_single && int'(fifo_cnt) < DEPTH
         && !(reg_rd && reg_addr == 2'd3))
        |=> (fifo_cnt == $past(fifo_cnt) + CNT_W'(1)));

    assert_full_stretch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !override && !buf_single && int'(fifo_cnt) > int'(trig))
        |-> scl_pull);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_cnt) <= DEPTH);

    assert_ready_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !(reg_wr && reg_addr == 2'd2 && !reg_wdata[1])) |=> ready);

    assert_ready_stretch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && buf_single && enable && !override) |-> scl_pull);

    assert_off_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !override) |-> !scl_pull);

    assert_sda_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !override |-> !sda_pull);

endmodule

bind i2c_rx_buffer i2c_rx_buffer_chk #(
    .DEPTH  (FIFO_DEPTH),
    .CNT_W  (CNT_W),
    .TRIG_W (TRIG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .scl_pull   (scl_pull),
    .sda_pull   (sda_pull),
    .enable     (ctrl_q.enable),
    .override   (ctrl_q.override),
    .buf_single (ctrl_q.buf_single),
    .fifo_cnt   (fifo_cnt),
    .trig       (trig_q),
    .ready      (ready_q)
);

// File: tb/i2c_rx_buffer_bench.sv
module i2c_rx_buffer_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_valid;
    logic [7:0] rx_byte;
    logic       reg_wr;
    logic       reg_rd;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       scl_drv;
    logic       sda_drv;
    logic       scl_in;
    logic       sda_in;
    logic       scl_pull;
    logic       sda_pull;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    // Open-drain bus model: the line is low if anyone pulls it
    assign scl_in = scl_drv & ~scl_pull;
    assign sda_in = sda_drv & ~sda_pull;

    i2c_rx_buffer u_i2c_rx_buffer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull)
    );

    // Vector: {op[1:0], addr[1:0], data[7:0], expect[7:0], req[3:0]}
    // op 0 = write, 1 = read and compare, 2 = receive byte, 3 = check scl_pull
    localparam int NV = 26;
    localparam logic [23:0] VEC [NV] = '{
        {2'd0, 2'd0, 8'h08, 8'h00, 4'd2},  // R2 enable, FIFO mode
        {2'd0, 2'd1, 8'h02, 8'h00, 4'd3},  // R3 threshold 3
        {2'd2, 2'd0, 8'hA1, 8'h00, 4'd2},  // R2
        {2'd2, 2'd0, 8'hB2, 8'h00, 4'd2},  // R2
        {2'd3, 2'd0, 8'h00, 8'h00, 4'd3},  // R3 below threshold
        {2'd1, 2'd2, 8'h00, 8'h10, 4'd2},  // R2 count 2
        {2'd2, 2'd0, 8'hC3, 8'h00, 4'd3},  // R3
        {2'd3, 2'd0, 8'h00, 8'h01, 4'd3},  // R3 stretch
        {2'd1, 2'd2, 8'h00, 8'h19, 4'd3},  // R3 full flag, count 3
        {2'd1, 2'd3, 8'h00, 8'hA1, 4'd2},  // R2 oldest first
        {2'd3, 2'd0, 8'h00, 8'h00, 4'd4},  // R4 released
        {2'd1, 2'd2, 8'h00, 8'h10, 4'd4},  // R4 flag clear
        {2'd1, 2'd3, 8'h00, 8'hB2, 4'd2},  // R2
        {2'd1, 2'd3, 8'h00, 8'hC3, 4'd2},  // R2
        {2'd1, 2'd2, 8'h00, 8'h00, 4'd2},  // R2 empty
        {2'd0, 2'd0, 8'h88, 8'h00, 4'd6},  // R6 single mode
        {2'd2, 2'd0, 8'h5E, 8'h00, 4'd6},  // R6
        {2'd3, 2'd0, 8'h00, 8'h01, 4'd6},  // R6 stretch
        {2'd1, 2'd3, 8'h00, 8'h5E, 4'd6},  // R6
        {2'd1, 2'd3, 8'h00, 8'h5E, 4'd6},  // R6 not consumed
        {2'd1, 2'd2, 8'h00, 8'h02, 4'd6},  // R6 ready
        {2'd0, 2'd2, 8'h02, 8'h00, 4'd6},  // R6 writing 1 keeps ready
        {2'd3, 2'd0, 8'h00, 8'h01, 4'd6},  // R6
        {2'd0, 2'd2, 8'h00, 8'h00, 4'd6},  // R6 clear
        {2'd3, 2'd0, 8'h00, 8'h00, 4'd6},  // R6 released
        {2'd1, 2'd2, 8'h00, 8'h00, 4'd6}   // R6
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle_strobes();
        rx_valid = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        idle_strobes();
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_mask(input logic [1:0] a, input logic [7:0] m,
                           input logic [7:0] exp, input string req);
        @(negedge clk);
        idle_strobes();
        reg_addr = a; reg_rd = 1'b1;
        #1 check(req, reg_rdata & m, exp);
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
        rd_mask(a, 8'hFF, exp, req);
    endtask

    task automatic rx(input logic [7:0] b);
        @(negedge clk);
        idle_strobes();
        rx_byte = b; rx_valid = 1'b1;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic chk_lines(input logic es, input logic ed, input string req);
        @(negedge clk);
        #1;
        check(req, {7'd0, scl_pull}, {7'd0, es});
        check(req, {7'd0, sda_pull}, {7'd0, ed});
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst_n = 1'b0; scl_drv = 1'b1; sda_drv = 1'b1;
        rx_byte = '0; reg_addr = '0; reg_wdata = '0;
        idle_strobes();
        repeat (3) @(negedge clk);

        // Reset state and live SCL readback while in reset
        chk_lines(1'b0, 1'b0, "R1");
        rd(2'd0, 8'h40, "R9 reset SCL high");
        scl_drv = 1'b0;
        repeat (3) @(negedge clk);
        rd_mask(2'd0, 8'h40, 8'h00, "R9 reset SCL low");
        scl_drv = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(2'd1, 8'h00, "R1 TRIG");
        rd(2'd2, 8'h00, "R1 STAT");
        rd(2'd0, 8'h40, "R1 CTRL");

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [1:0] op, ad;
            logic [7:0] dt, ex;
            string      tag;
            {op, ad, dt, ex} = VEC[i][23:4];
            tag = $sformatf("R%0d vec %0d", VEC[i][3:0], i);
            case (op)
                2'd0: wr(ad, dt);
                2'd1: rd(ad, ex, tag);
                2'd2: rx(dt);
                default: begin
                    @(negedge clk); #1;
                    check(tag, {7'd0, scl_pull}, ex);
                end
            endcase
        end

        // R5: fill to 16, drop the 17th, drain, read empty
        wr(2'd0, 8'h08);
        wr(2'd1, 8'h0F);
        for (int i = 0; i < 17; i++) rx(8'h40 + 8'(i));
        rd(2'd2, 8'h81, "R5 full count 16");
        chk_lines(1'b1, 1'b0, "R5 stretch at 16");
        for (int i = 0; i < 16; i++) rd(2'd3, 8'h40 + 8'(i), "R5 drain order");
        rd(2'd3, 8'h00, "R5 empty read");
        rd(2'd2, 8'h00, "R5 empty count");

        // R7: disable ignores bytes and releases SCL
        wr(2'd1, 8'h00);
        rx(8'h11);
        chk_lines(1'b1, 1'b0, "R7 enabled stretch");
        wr(2'd0, 8'h00);
        chk_lines(1'b0, 1'b0, "R7 disabled release");
        rx(8'h22);
        rd(2'd2, 8'h09, "R7 FIFO byte ignored");
        wr(2'd0, 8'h80);
        rx(8'h33);
        rd(2'd2, 8'h09, "R7 single byte ignored");
        chk_lines(1'b0, 1'b0, "R7 single disabled");
        wr(2'd0, 8'h08);
        rd(2'd3, 8'h11, "R7 first byte kept");
        rd(2'd2, 8'h00, "R7 drained");
        wr(2'd0, 8'h00);

        // R10: START/STOP detection
        sda_drv = 1'b0;
        repeat (4) @(negedge clk);
        rd_mask(2'd0, 8'h20, 8'h20, "R10 busy after START");
        sda_drv = 1'b1;
        repeat (4) @(negedge clk);
        rd_mask(2'd0, 8'h20, 8'h00, "R10 idle after STOP");
        scl_drv = 1'b0;
        repeat (4) @(negedge clk);
        sda_drv = 1'b0;
        repeat (4) @(negedge clk);
        rd_mask(2'd0, 8'h20, 8'h00, "R10 SDA fall with SCL low");
        sda_drv = 1'b1;
        repeat (4) @(negedge clk);
        scl_drv = 1'b1;
        repeat (4) @(negedge clk);

        // R8: override drives the lines
        wr(2'd0, 8'h10);
        chk_lines(1'b1, 1'b1, "R8 both pulled");
        wr(2'd0, 8'h50);
        chk_lines(1'b0, 1'b1, "R8 SDA only");
        wr(2'd0, 8'h30);
        chk_lines(1'b1, 1'b0, "R8 SCL only");
        wr(2'd0, 8'h70);
        chk_lines(1'b0, 1'b0, "R8 both released");
        wr(2'd0, 8'h00);
        chk_lines(1'b0, 1'b0, "R8 override off");

        repeat (2) @(negedge clk);
        summary();
    end

endmodule